// File: doc/BRIEF.md
# I2C Control-Byte Command/Data Router

This block is the write side of a display controller's two-wire serial port. It runs on a fast system clock that oversamples the bus clock and data lines. It finds START and STOP conditions and matches its own 7-bit device address. It acknowledges each byte it takes. It then passes payload bytes to one of two outputs: a command output, or a display-RAM data output.

The first byte after the address is a control byte. Its two high flags pick where the payload goes. They also pick whether exactly one payload byte follows, or an open-ended stream that only a STOP ends. After a single-byte payload the next byte is read as a fresh control byte, so mixed command and data sequences can be chained inside one transfer without a STOP.

Each data byte also raises a pointer-advance strobe for one cycle, so the RAM address logic moves to the next location. The payload outputs are valid-only streams with no ready input. The bus cannot be stalled, so any consumer must take each one-cycle valid pulse in the cycle it appears. Back-pressure is never applied.

Top module: `i2c_ctl_router`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high; bus bits are sampled on SCL rising edges. The block reacts to bytes only after a START, and bytes clocked after a STOP with no new START give no acknowledge and no output.
- R2: For an address byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 (read/write) is 0, the block pulls SDA low (`sda_oe_o` = 1). It does so from the SCL falling edge after the eighth bit until the next SCL falling edge.
- R3: For an address mismatch, or for bit 0 = 1, the block gives no acknowledge. It then produces no acknowledge and no output for any byte until the next START.
- R4: The byte after an accepted address is a control byte and is acknowledged. Its bit 7 is the single-byte flag and its bit 6 is the data flag; bits 5..0 are not used.
- R5: When the data flag is 0, each payload byte appears on `cmd_data_o` with a one-cycle `cmd_valid_o` pulse. When the data flag is 1, each payload byte appears on `ram_data_o` with a one-cycle `ram_valid_o` pulse, and `ptr_adv_o` pulses in the same cycle. The two valid outputs are never high together.
- R6: With the single-byte flag at 1, exactly one payload byte follows, and the byte after it is read as a new control byte.
- R7: With the single-byte flag at 0, every following byte is payload of the same kind until a STOP.
- R8: A START or repeated START at any point ends the current sequence; the next byte is read as an address byte.
- R9: Every payload byte of an accepted transfer is acknowledged.
- R10: `sda_oe_o` is 0 outside acknowledge slots and after reset, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge); 0 releases it |
| cmd_valid_o | output | 1 | One-cycle pulse: command byte on `cmd_data_o` |
| cmd_data_o | output | 8 | Command byte |
| ram_valid_o | output | 1 | One-cycle pulse: display-RAM data byte on `ram_data_o` |
| ram_data_o | output | 8 | Display-RAM data byte |
| ptr_adv_o | output | 1 | One-cycle pulse to advance the display-RAM pointer |

## Verification
The sequences used are:
- single command and single data transfers;
- single-byte sequences chained within one transfer, which shows that the control byte re-arms after one payload byte;
- streams of commands and streams of data, which show that no control byte is looked for again before a STOP.

Wrong addresses, read requests and bytes sent after a STOP with no new START check that the block stays silent and does not acknowledge. Repeated STARTs are sent inside a stream, right after a control byte, and with a wrong address. These show that each repeated START throws away the old routing state and re-reads an address.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_PAYLOAD,
    ST_IGNORE
  } rtr_state_e;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else        stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/i2cr_cond.sv
module i2cr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_o = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/i2cr_shift.sv
module i2cr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (shift_i && !full_o) begin
      cnt    <= cnt + 1'b1;
      data_o <= {data_o[W-2:0], bit_i};
    end
  end

  assign full_o = (cnt == FULL);
endmodule

// File: rtl/i2c_ctl_router.sv
module i2c_ctl_router #(
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h3C,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W:0]   cmd_data_o,
  output logic              ram_valid_o,
  output logic [ADDR_W:0]   ram_data_o,
  output logic              ptr_adv_o
);
  import i2cr_pkg::*;

  localparam int BYTE_W = ADDR_W + 1;

  logic [1:0]        lines_s;
  logic              scl_s, sda_s;
  logic              start, stop, rise, fall;
  logic              in_ack;
  logic              co_r, dc_r;
  logic [BYTE_W-1:0] byte_v;
  logic              byte_full;
  logic              shift_en, shift_clr;
  rtr_state_e        st;

  i2cr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({scl_i, sda_i}), .sync_o(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cr_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  assign shift_en  = rise && !in_ack &&
                     (st == ST_ADDR || st == ST_CTRL || st == ST_PAYLOAD);
  assign shift_clr = start || stop || (fall && in_ack);

  i2cr_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(shift_clr), .shift_i(shift_en),
    .bit_i(sda_s), .data_o(byte_v), .full_o(byte_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      in_ack      <= 1'b0;
      sda_oe_o    <= 1'b0;
      co_r        <= 1'b0;
      dc_r        <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_data_o  <= '0;
      ram_valid_o <= 1'b0;
      ram_data_o  <= '0;
      ptr_adv_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      ram_valid_o <= 1'b0;
      ptr_adv_o   <= 1'b0;
      if (start) begin
        st       <= ST_ADDR;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop) begin
        st       <= ST_IDLE;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (fall) begin
        if (in_ack) begin
          in_ack   <= 1'b0;
          sda_oe_o <= 1'b0;
        end else if (byte_full) begin
          unique case (st)
            ST_ADDR: begin
              if (byte_v[BYTE_W-1:1] == DEV_ADDR && !byte_v[0]) begin
                st       <= ST_CTRL;
                in_ack   <= 1'b1;
                sda_oe_o <= 1'b1;
              end else begin
                st <= ST_IGNORE;
              end
            end
            ST_CTRL: begin
              co_r     <= byte_v[BYTE_W-1];
              dc_r     <= byte_v[BYTE_W-2];
              st       <= ST_PAYLOAD;
              in_ack   <= 1'b1;
              sda_oe_o <= 1'b1;
            end
            ST_PAYLOAD: begin
              if (dc_r) begin
                ram_valid_o <= 1'b1;
                ram_data_o  <= byte_v;
                ptr_adv_o   <= 1'b1;
              end else begin
                cmd_valid_o <= 1'b1;
                cmd_data_o  <= byte_v;
              end
              if (co_r) st <= ST_CTRL;
              in_ack   <= 1'b1;
              sda_oe_o <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic cmd_valid_o,
  input logic ram_valid_o,
  input logic ptr_adv_o
);
  // R5: command pulses last one cycle
  a_r5_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R5: data pulses last one cycle
  a_r5_ram_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid_o |=> !ram_valid_o);

  // R5: command and data never together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && ram_valid_o));

  // R5: pointer advance accompanies each data byte
  a_r5_ptr_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid_o |-> ptr_adv_o);

  // R10: acknowledge drive changes only while SCL is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R2: acknowledge begins after an SCL fall
  a_r2_ack_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_ctl_router i2cr_checker u_chk (.*);

// File: tb/i2c_ctl_router_bench.sv
module i2c_ctl_router_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe_o, cmd_valid_o, ram_valid_o, ptr_adv_o;
  logic [7:0] cmd_data_o, ram_data_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe_o;

  i2c_ctl_router u_i2c_ctl_router (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o),
    .ram_valid_o(ram_valid_o), .ram_data_o(ram_data_o), .ptr_adv_o(ptr_adv_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; waitq();
    scl_drv = 1'b1; waitq();
    sda_drv = 1'b0; waitq();
    scl_drv = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; waitq();
    scl_drv = 1'b1; waitq();
    sda_drv = 1'b1; waitq();
  endtask

  task automatic push_cmd(input logic [7:0] b);
    exp_q.push_back({1'b0, b});
  endtask

  task automatic push_ram(input logic [7:0] b);
    exp_q.push_back({1'b1, b});
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit oe_seen = 1'b0;
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; waitq();
      scl_drv = 1'b1; waitq();
      if (sda_oe_o) oe_seen = 1'b1;
      waitq();
      scl_drv = 1'b0; waitq();
    end
    chk(!oe_seen, "R10 sda driven during data bits", oe_seen, 0);
    sda_drv = 1'b1; waitq();
    scl_drv = 1'b1; waitq();
    ack = !sda_line;
    chk(ack == exp_ack, req, ack, exp_ack);
    waitq();
    scl_drv = 1'b0; waitq();
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (cmd_valid_o || ram_valid_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R5 unexpected payload", {ram_valid_o, ram_valid_o ? ram_data_o : cmd_data_o}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (e[8]) begin
          chk(ram_valid_o && !cmd_valid_o && ram_data_o == e[7:0], "R5 data byte",
              {ram_valid_o, ram_data_o}, {1'b1, e[7:0]});
          chk(ptr_adv_o, "R5 pointer advance with data", ptr_adv_o, 1);
        end else begin
          chk(cmd_valid_o && !ram_valid_o && cmd_data_o == e[7:0], "R5 command byte",
              {cmd_valid_o, cmd_data_o}, {1'b1, e[7:0]});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!sda_oe_o && !cmd_valid_o && !ram_valid_o && !ptr_adv_o, "R10 reset state",
        {sda_oe_o, cmd_valid_o, ram_valid_o, ptr_adv_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R4 R9 single command
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h80, 1, "R4 control ack");
    push_cmd(8'hA5);
    send_byte(8'hA5, 1, "R9 payload ack");
    bus_stop();
    drained("R5 single command delivered");

    // R6 chained single-byte sequences
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h80, 1, "R6 control ack");
    push_cmd(8'h11); send_byte(8'h11, 1, "R9 payload ack");
    send_byte(8'hC0, 1, "R6 second control ack");
    push_ram(8'h22); send_byte(8'h22, 1, "R9 payload ack");
    send_byte(8'h80, 1, "R6 third control ack");
    push_cmd(8'h33); send_byte(8'h33, 1, "R9 payload ack");
    bus_stop();
    drained("R6 chained sequences");

    // R7 data stream, then command stream
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h40, 1, "R4 control ack");
    for (int i = 0; i < 5; i++) begin
      push_ram(8'h80 | 8'(i)); send_byte(8'h80 | 8'(i), 1, "R7 stream data ack");
    end
    push_ram(8'hC0); send_byte(8'hC0, 1, "R7 control-looking byte is data");
    bus_stop();
    drained("R7 data stream");
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h00, 1, "R4 control ack");
    push_cmd(8'h80); send_byte(8'h80, 1, "R7 stream command ack");
    push_cmd(8'h5C); send_byte(8'h5C, 1, "R7 stream command ack");
    bus_stop();
    drained("R7 command stream");

    // R3 address mismatch and read request
    bus_start();
    send_byte(8'h7A, 0, "R3 mismatch nack");
    send_byte(8'h80, 0, "R3 ignored byte nack");
    send_byte(8'hA5, 0, "R3 ignored byte nack");
    bus_stop();
    drained("R3 mismatch no output");
    bus_start();
    send_byte(8'h79, 0, "R3 read request nack");
    send_byte(8'h80, 0, "R3 ignored byte nack");
    send_byte(8'h12, 0, "R3 ignored byte nack");
    bus_stop();
    drained("R3 read no output");

    // R1 bytes after STOP without START
    send_byte(8'h78, 0, "R1 no start nack");
    send_byte(8'h80, 0, "R1 no start nack");
    drained("R1 no output without start");

    // R8 repeated START inside a stream
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h40, 1, "R4 control ack");
    push_ram(8'h01); send_byte(8'h01, 1, "R9 payload ack");
    bus_start();
    send_byte(8'h78, 1, "R8 address after repeated start");
    send_byte(8'h80, 1, "R8 control after repeated start");
    push_cmd(8'h5A); send_byte(8'h5A, 1, "R9 payload ack");
    bus_stop();
    drained("R8 stream aborted by repeated start");

    // R8 repeated START right after a control byte
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'hC0, 1, "R4 control ack");
    bus_start();
    send_byte(8'h78, 1, "R8 address after repeated start");
    send_byte(8'h80, 1, "R8 control after repeated start");
    push_cmd(8'h09); send_byte(8'h09, 1, "R9 payload ack");
    bus_stop();
    drained("R8 control discarded by repeated start");

    // R8 repeated START with a wrong address
    bus_start();
    send_byte(8'h78, 1, "R2 address ack");
    send_byte(8'h40, 1, "R4 control ack");
    bus_start();
    send_byte(8'h7C, 0, "R8 R3 wrong address after repeated start");
    send_byte(8'h44, 0, "R3 ignored byte nack");
    bus_stop();
    drained("R8 no output after wrong address");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule